// File: doc/BRIEF.md
# E1 Transmit Timeslot Source Multiplexer

This block assembles the outgoing 2.048 Mbit/s E1 bit stream one bit at a time. A frame position counter outside the block supplies the timeslot index, the bit index within the timeslot, a flag for frames that carry the alignment word, and the frame number within the signaling multiframe. On each bit strobe, the block picks the source of the current bit. The choices are the unframed serial input, one of two timeslot 0 words (the alignment word and the non-alignment word), a signaling byte, a separate link data input, or a forced one.

Control inputs set the source independently for timeslot 0 and timeslot 16. Timeslot 0 can pass through from the serial input or come from the words, and the international bit has its own select. Each national bit Sa4 to Sa8 can be switched over to the link input on its own. Timeslot 16 can come from the serial input or from the signaling bytes, or it can be forced to ones. A separate control forces the whole stream to ones. A one-cycle demand clock marks each bit taken from the link input, so the link source can present its next bit. CRC-4, line coding and multiframe generation are handled outside this block.

The chosen source is held as the state of a small machine: SRC_IDLE, SRC_SER, SRC_WORD, SRC_SIG, SRC_LINK and SRC_ONES. Reset enters SRC_IDLE. Every bit strobe moves to the state picked by a fixed priority, in this order:
- SRC_ONES when the stream is forced, or when timeslot 16 is forced.
- SRC_LINK for an enabled national bit.
- SRC_WORD or SRC_SER for the international bit.
- SRC_WORD or SRC_SER for the rest of timeslot 0.
- SRC_SIG or SRC_SER for timeslot 16.
- SRC_SER otherwise.

Without a strobe the state is held.

Top module: `e1_tx_slot_mux`

## Requirements
- R1: After reset and until the first bit strobe, `tx_o` is 1 and `link_clk_o` is 0.
- R2: `tx_o` changes only in the clock cycle after a cycle with `bit_en_i` high, and otherwise holds its value.
- R3: In timeslots other than 0 and 16, the output bit is the `ser_i` value sampled at the strobe.
- R4: In timeslot 0, bit indices 1 to 7 are taken from `ser_i` when `ts0_pass_i` is 1. When it is 0, they come from bit (7 - bit index) of `fas_word_i` in frames with `fas_frame_i`=1, and of `nfas_word_i` otherwise. Bit index 0 is sent first.
- R5: Bit index 0 of timeslot 0 (the international bit) comes from bit 7 of the frame's word when `si_reg_i` is 1. When `si_reg_i` is 0 it comes from `ser_i`, whatever the value of `ts0_pass_i`.
- R6: In timeslot 0 of frames with `fas_frame_i`=0, bit indices 3 to 7 are Sa4 to Sa8. Each of these bits is enabled by `sa_en_i[bit index - 3]`. An enabled bit is taken from `link_i`, ahead of pass-through and the words. In frames with `fas_frame_i`=1, `sa_en_i` has no effect.
- R7: `link_clk_o` is high for exactly the one cycle in which `tx_o` presents a bit taken from `link_i`, and is low in every other cycle.
- R8: In timeslot 16, when `ts16_reg_i` is 1 the bit is bit (7 - bit index) of byte `mf_frame_i` of `sig_bytes_i`, where byte k occupies bits [8k+7:8k]. When `ts16_reg_i` is 0 the bit comes from `ser_i`.
- R9: `sig_ones_i`=1 forces every bit of timeslot 16 to 1, over `ts16_reg_i` and `ser_i`. It leaves the other timeslots unchanged.
- R10: `ufr_ones_i`=1 forces every output bit to 1 and suppresses `link_clk_o`. It takes priority over all other controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | One-cycle strobe per E1 bit time |
| ts_idx_i | input | 5 | Timeslot index 0..31 |
| bit_idx_i | input | 3 | Bit index within timeslot, 0 sent first |
| fas_frame_i | input | 1 | 1 in frames carrying the alignment word |
| mf_frame_i | input | 4 | Frame number within the signaling multiframe |
| ser_i | input | 1 | Unframed serial transmit data |
| link_i | input | 1 | Link data for national bits |
| ufr_ones_i | input | 1 | Force whole stream to ones |
| sig_ones_i | input | 1 | Force timeslot 16 to ones |
| ts0_pass_i | input | 1 | Timeslot 0 from serial input |
| ts16_reg_i | input | 1 | Timeslot 16 from signaling bytes |
| si_reg_i | input | 1 | International bit from the words |
| sa_en_i | input | 5 | Per-bit link enable, bit 0 = Sa4 |
| fas_word_i | input | 8 | Timeslot 0 word for alignment frames |
| nfas_word_i | input | 8 | Timeslot 0 word for non-alignment frames |
| sig_bytes_i | input | 128 | Sixteen signaling bytes, byte k at [8k+7:8k] |
| tx_o | output | 1 | Assembled E1 bit |
| link_clk_o | output | 1 | Demand pulse for each bit taken from `link_i` |

## Verification
The bench targets the priority edges where one source overlaps another:
- An enabled national bit while pass-through is on, where a design with the order wrong sends the serial bit.
- The international bit with pass-through off but its own select off, where a design that follows pass-through sends the word bit.
- Link enables in an alignment frame, which must not steal bits or pulse the demand clock.
- Forced ones in timeslot 16 against the neighbouring timeslot 17.
- Unframed ones on a national bit, which must also silence the demand clock.

Further tests walk a whole timeslot 0 with a sparse enable pattern to count demand pulses. They also hold the strobe low while the serial input changes, to catch an output that is not registered.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;

    // Source selected for the bit currently on the line.
    typedef enum logic [2:0] {
        SRC_IDLE = 3'd0,
        SRC_SER  = 3'd1,
        SRC_WORD = 3'd2,
        SRC_SIG  = 3'd3,
        SRC_LINK = 3'd4,
        SRC_ONES = 3'd5
    } src_t;

    localparam int TS_ALIGN = 0;
    localparam int TS_SIGNAL = 16;

endpackage

// File: rtl/e1tx_slot_decode.sv
module e1tx_slot_decode #(
    parameter int TS_W     = 5,
    parameter int WORD_W   = 8,
    parameter int SA_COUNT = 5,
    parameter int BIT_W    = $clog2(WORD_W)
) (
    input  logic [TS_W-1:0]     ts_idx_i,
    input  logic [BIT_W-1:0]    bit_idx_i,
    input  logic                fas_frame_i,
    output logic                in_ts0_o,
    output logic                in_ts16_o,
    output logic                is_si_o,
    output logic [SA_COUNT-1:0] sa_pos_o
);
    import e1tx_pkg::*;

    localparam int SA_FIRST = WORD_W - SA_COUNT;

    assign in_ts0_o  = (ts_idx_i == TS_W'(TS_ALIGN));
    assign in_ts16_o = (ts_idx_i == TS_W'(TS_SIGNAL));
    assign is_si_o   = in_ts0_o && (bit_idx_i == '0);

    // One decode term per national bit position; only frames without
    // the alignment word carry them.
    for (genvar g = 0; g < SA_COUNT; g++) begin : g_sa
        assign sa_pos_o[g] = in_ts0_o && !fas_frame_i &&
                             (bit_idx_i == BIT_W'(SA_FIRST + g));
    end

endmodule

// File: rtl/e1tx_sig_pick.sv
module e1tx_sig_pick #(
    parameter int WORD_W    = 8,
    parameter int SIG_BYTES = 16,
    parameter int BIT_W     = $clog2(WORD_W),
    parameter int MF_W      = $clog2(SIG_BYTES)
) (
    input  logic [SIG_BYTES*WORD_W-1:0] sig_bytes_i,
    input  logic [MF_W-1:0]             mf_frame_i,
    input  logic [BIT_W-1:0]            bit_idx_i,
    output logic                        sig_bit_o
);
    logic [WORD_W-1:0] byte_arr [SIG_BYTES];
    logic [WORD_W-1:0] cur_byte;

    for (genvar k = 0; k < SIG_BYTES; k++) begin : g_byte
        assign byte_arr[k] = sig_bytes_i[k*WORD_W +: WORD_W];
    end

    assign cur_byte  = byte_arr[mf_frame_i];
    // Bit index 0 is the first bit on the line, i.e. the byte MSB.
    assign sig_bit_o = cur_byte[BIT_W'(WORD_W - 1) - bit_idx_i];

endmodule

// File: rtl/e1tx_src_arbiter.sv
module e1tx_src_arbiter #(
    parameter int SA_COUNT = 5
) (
    input  logic                ufr_ones_i,
    input  logic                sig_ones_i,
    input  logic                ts0_pass_i,
    input  logic                ts16_reg_i,
    input  logic                si_reg_i,
    input  logic [SA_COUNT-1:0] sa_en_i,
    input  logic                in_ts0_i,
    input  logic                in_ts16_i,
    input  logic                is_si_i,
    input  logic [SA_COUNT-1:0] sa_pos_i,
    output e1tx_pkg::src_t      src_o
);
    import e1tx_pkg::*;

    logic sa_take;

    assign sa_take = |(sa_pos_i & sa_en_i);

    // Fixed priority: stream ones, signaling ones, link, Si, TS0, TS16.
    always_comb begin
        if (ufr_ones_i) begin
            src_o = SRC_ONES;
        end else if (in_ts16_i && sig_ones_i) begin
            src_o = SRC_ONES;
        end else if (sa_take) begin
            src_o = SRC_LINK;
        end else if (is_si_i) begin
            src_o = si_reg_i ? SRC_WORD : SRC_SER;
        end else if (in_ts0_i) begin
            src_o = ts0_pass_i ? SRC_SER : SRC_WORD;
        end else if (in_ts16_i) begin
            src_o = ts16_reg_i ? SRC_SIG : SRC_SER;
        end else begin
            src_o = SRC_SER;
        end
    end

endmodule

// File: rtl/e1_tx_slot_mux.sv
module e1_tx_slot_mux #(
    parameter int TS_W      = 5,
    parameter int WORD_W    = 8,
    parameter int SA_COUNT  = 5,
    parameter int SIG_BYTES = 16,
    parameter int BIT_W     = $clog2(WORD_W),
    parameter int MF_W      = $clog2(SIG_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bit_en_i,
    input  logic [TS_W-1:0]             ts_idx_i,
    input  logic [BIT_W-1:0]            bit_idx_i,
    input  logic                        fas_frame_i,
    input  logic [MF_W-1:0]             mf_frame_i,
    input  logic                        ser_i,
    input  logic                        link_i,
    input  logic                        ufr_ones_i,
    input  logic                        sig_ones_i,
    input  logic                        ts0_pass_i,
    input  logic                        ts16_reg_i,
    input  logic                        si_reg_i,
    input  logic [SA_COUNT-1:0]         sa_en_i,
    input  logic [WORD_W-1:0]           fas_word_i,
    input  logic [WORD_W-1:0]           nfas_word_i,
    input  logic [SIG_BYTES*WORD_W-1:0] sig_bytes_i,
    output logic                        tx_o,
    output logic                        link_clk_o
);
    import e1tx_pkg::*;

    logic                in_ts0, in_ts16, is_si;
    logic [SA_COUNT-1:0] sa_pos;
    logic                sig_bit;
    logic                word_bit;
    logic [WORD_W-1:0]   frame_word;
    src_t                src_d, src_q;
    logic                ser_q, link_q, word_q, sig_q, lclk_q;

    e1tx_slot_decode #(
        .TS_W(TS_W), .WORD_W(WORD_W), .SA_COUNT(SA_COUNT), .BIT_W(BIT_W)
    ) u_decode (
        .ts_idx_i   (ts_idx_i),
        .bit_idx_i  (bit_idx_i),
        .fas_frame_i(fas_frame_i),
        .in_ts0_o   (in_ts0),
        .in_ts16_o  (in_ts16),
        .is_si_o    (is_si),
        .sa_pos_o   (sa_pos)
    );

    e1tx_src_arbiter #(.SA_COUNT(SA_COUNT)) u_arb (
        .ufr_ones_i(ufr_ones_i),
        .sig_ones_i(sig_ones_i),
        .ts0_pass_i(ts0_pass_i),
        .ts16_reg_i(ts16_reg_i),
        .si_reg_i  (si_reg_i),
        .sa_en_i   (sa_en_i),
        .in_ts0_i  (in_ts0),
        .in_ts16_i (in_ts16),
        .is_si_i   (is_si),
        .sa_pos_i  (sa_pos),
        .src_o     (src_d)
    );

    e1tx_sig_pick #(
        .WORD_W(WORD_W), .SIG_BYTES(SIG_BYTES), .BIT_W(BIT_W), .MF_W(MF_W)
    ) u_sig (
        .sig_bytes_i(sig_bytes_i),
        .mf_frame_i (mf_frame_i),
        .bit_idx_i  (bit_idx_i),
        .sig_bit_o  (sig_bit)
    );

    assign frame_word = fas_frame_i ? fas_word_i : nfas_word_i;
    assign word_bit   = frame_word[BIT_W'(WORD_W - 1) - bit_idx_i];

    // State register: source and the candidate bits captured at the strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= SRC_IDLE;
            ser_q  <= 1'b1;
            link_q <= 1'b1;
            word_q <= 1'b1;
            sig_q  <= 1'b1;
            lclk_q <= 1'b0;
        end else if (bit_en_i) begin
            src_q  <= src_d;
            ser_q  <= ser_i;
            link_q <= link_i;
            word_q <= word_bit;
            sig_q  <= sig_bit;
            lclk_q <= (src_d == SRC_LINK);
        end else begin
            lclk_q <= 1'b0;
        end
    end

    // Output process: the state names the bit on the line.
    always_comb begin
        unique case (src_q)
            SRC_IDLE: tx_o = 1'b1;
            SRC_SER:  tx_o = ser_q;
            SRC_WORD: tx_o = word_q;
            SRC_SIG:  tx_o = sig_q;
            SRC_LINK: tx_o = link_q;
            SRC_ONES: tx_o = 1'b1;
            default:  tx_o = 1'b1;
        endcase
    end

    assign link_clk_o = lclk_q;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en_i |=> $stable(tx_o));

    assert_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en_i && ufr_ones_i |=> tx_o && !link_clk_o);

    assert_sig_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en_i && (ts_idx_i == TS_W'(TS_SIGNAL)) && sig_ones_i |=> tx_o);

    assert_dclk_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en_i && ((ts_idx_i != TS_W'(TS_ALIGN)) || fas_frame_i) |=> !link_clk_o);

    assert_link_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en_i && !ufr_ones_i && |(sa_en_i & sa_pos) |=> tx_o == $past(link_i));

endmodule

// File: tb/e1_tx_slot_mux_tb.sv
module e1_tx_slot_mux_tb_top;

    typedef struct packed {
        logic       uo;
        logic       so;
        logic       pass;
        logic       t16;
        logic       si;
        logic [4:0] sa;
        logic [4:0] ts;
        logic [2:0] bt;
        logic       fas;
        logic [3:0] mf;
        logic       ser;
        logic       link;
        logic       exp;
        logic       lclk;
    } vec_t;

    localparam int NV = 22;
    // fas_word = 8'h9B, nfas_word = 8'h5A, sig byte k = {k, ~k}
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h00,5'd5, 3'd2,1'b0,4'd0,1'b1,1'b0,1'b1,1'b0}, // R3
        '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h00,5'd5, 3'd2,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0}, // R3
        '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h00,5'd0, 3'd3,1'b1,4'd0,1'b0,1'b0,1'b1,1'b0}, // R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h00,5'd0, 3'd1,1'b1,4'd0,1'b1,1'b0,1'b0,1'b0}, // R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h00,5'd0, 3'd2,1'b0,4'd0,1'b1,1'b0,1'b0,1'b0}, // R4
        '{1'b0,1'b0,1'b1,1'b0,1'b0,5'h00,5'd0, 3'd1,1'b1,4'd0,1'b1,1'b0,1'b1,1'b0}, // R4
        '{1'b0,1'b0,1'b1,1'b0,1'b0,5'h00,5'd0, 3'd4,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0}, // R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h00,5'd0, 3'd0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0}, // R5
        '{1'b0,1'b0,1'b0,1'b0,1'b1,5'h00,5'd0, 3'd0,1'b1,4'd0,1'b0,1'b0,1'b1,1'b0}, // R5
        '{1'b0,1'b0,1'b0,1'b0,1'b1,5'h00,5'd0, 3'd0,1'b0,4'd0,1'b1,1'b0,1'b0,1'b0}, // R5
        '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h04,5'd0, 3'd5,1'b0,4'd0,1'b0,1'b1,1'b1,1'b1}, // R6
        '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h1B,5'd0, 3'd5,1'b0,4'd0,1'b0,1'b1,1'b0,1'b0}, // R6
        '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h1F,5'd0, 3'd5,1'b1,4'd0,1'b0,1'b1,1'b0,1'b0}, // R6
        '{1'b0,1'b0,1'b1,1'b0,1'b0,5'h10,5'd0, 3'd7,1'b0,4'd0,1'b1,1'b0,1'b0,1'b1}, // R6
        '{1'b0,1'b0,1'b0,1'b1,1'b0,5'h00,5'd16,3'd2,1'b0,4'd3,1'b0,1'b0,1'b1,1'b0}, // R8
        '{1'b0,1'b0,1'b0,1'b1,1'b0,5'h00,5'd16,3'd2,1'b0,4'd5,1'b1,1'b0,1'b0,1'b0}, // R8
        '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h00,5'd16,3'd2,1'b0,4'd3,1'b0,1'b0,1'b0,1'b0}, // R8
        '{1'b0,1'b1,1'b0,1'b1,1'b0,5'h00,5'd16,3'd0,1'b0,4'd3,1'b0,1'b0,1'b1,1'b0}, // R9
        '{1'b0,1'b1,1'b0,1'b0,1'b0,5'h00,5'd17,3'd0,1'b0,4'd0,1'b0,1'b0,1'b0,1'b0}, // R9
        '{1'b1,1'b0,1'b0,1'b0,1'b0,5'h1F,5'd0, 3'd5,1'b0,4'd0,1'b0,1'b0,1'b1,1'b0}, // R10
        '{1'b1,1'b0,1'b0,1'b0,1'b0,5'h00,5'd9, 3'd0,1'b0,4'd0,1'b0,1'b0,1'b1,1'b0}, // R10
        '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h00,5'd0, 3'd1,1'b0,4'd0,1'b0,1'b0,1'b1,1'b0}  // R4
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_en = 1'b0;
    logic [4:0]   ts_idx = '0;
    logic [2:0]   bit_idx = '0;
    logic         fas_frame = 1'b0;
    logic [3:0]   mf_frame = '0;
    logic         ser = 1'b0, link = 1'b0;
    logic         ufr_ones = 1'b0, sig_ones = 1'b0, ts0_pass = 1'b0;
    logic         ts16_reg = 1'b0, si_reg = 1'b0;
    logic [4:0]   sa_en = '0;
    logic [7:0]   fas_word = 8'h9B, nfas_word = 8'h5A;
    logic [127:0] sig_bytes;
    logic         tx, link_clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    e1_tx_slot_mux dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en_i(bit_en), .ts_idx_i(ts_idx),
        .bit_idx_i(bit_idx), .fas_frame_i(fas_frame), .mf_frame_i(mf_frame),
        .ser_i(ser), .link_i(link), .ufr_ones_i(ufr_ones), .sig_ones_i(sig_ones),
        .ts0_pass_i(ts0_pass), .ts16_reg_i(ts16_reg), .si_reg_i(si_reg),
        .sa_en_i(sa_en), .fas_word_i(fas_word), .nfas_word_i(nfas_word),
        .sig_bytes_i(sig_bytes), .tx_o(tx), .link_clk_o(link_clk)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one strobe at a falling edge, sample at the next falling edge.
    task automatic strobe(input vec_t v);
        ufr_ones = v.uo; sig_ones = v.so; ts0_pass = v.pass;
        ts16_reg = v.t16; si_reg = v.si; sa_en = v.sa;
        ts_idx = v.ts; bit_idx = v.bt; fas_frame = v.fas; mf_frame = v.mf;
        ser = v.ser; link = v.link; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    initial begin
        int pulses;
        vec_t v;
        for (int k = 0; k < 16; k++) begin
            sig_bytes[k*8 +: 8] = {4'(k), ~4'(k)};
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state before first strobe
        check("R1 tx idle", tx, 1'b1);
        check("R1 demand clock idle", link_clk, 1'b0);

        for (int i = 0; i < NV; i++) begin
            strobe(VECS[i]);
            check($sformatf("vector %0d tx", i), tx, VECS[i].exp);
            check($sformatf("vector %0d link_clk", i), link_clk, VECS[i].lclk);
        end

        // R2: output holds while strobe is low and serial input moves
        v = VECS[0];
        strobe(v);
        ser = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 hold tx", tx, 1'b1);
        check("R2 no demand pulse without strobe", link_clk, 1'b0);

        // R6/R7: walk a non-FAS timeslot 0 with Sa4, Sa6, Sa8 enabled
        pulses = 0;
        for (int b = 0; b < 8; b++) begin
            v = VECS[0];
            v.ts = 5'd0; v.bt = 3'(b); v.fas = 1'b0; v.sa = 5'b10101;
            v.ser = 1'b0; v.link = 1'b1;
            strobe(v);
            if (link_clk) pulses++;
            if (b == 3 || b == 5 || b == 7) check("R6 walk link bit", tx, 1'b1);
        end
        checks++;
        if (pulses != 3) begin
            errors++;
            $display("FAIL R7 pulse count: actual=%0d expected=3", pulses);
        end

        // R7: same enables in an alignment frame give no pulses
        pulses = 0;
        for (int b = 0; b < 8; b++) begin
            v = VECS[0];
            v.ts = 5'd0; v.bt = 3'(b); v.fas = 1'b1; v.sa = 5'b11111;
            v.link = 1'b1;
            strobe(v);
            if (link_clk) pulses++;
        end
        checks++;
        if (pulses != 0) begin
            errors++;
            $display("FAIL R7 FAS frame pulses: actual=%0d expected=0", pulses);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule